// File: doc/BRIEF.md
# CCD Readout Clock Sequencer

This block produces the digital timing waveforms that read out a two-phase full-frame CCD after integration. While idle it holds both vertical phases low, so the array integrates. The horizontal phase A stays high during that time. A one-cycle `start` pulse begins readout. For each line, the block drives the two vertical phases in turn, which moves the row into the horizontal register. The row is handed over when vertical phase B falls while horizontal phase A is high.

The block then shifts the line out one pixel at a time. The two horizontal phases toggle as a complementary pair. Each falling edge of horizontal phase B places a new packet on the output node. A fixed number of cycles after that edge, the block issues a one-cycle sample strobe for the external converter. The node reset gate is then pulsed, and it always finishes before horizontal phase B rises again. After the last pixel of the last line, a one-cycle `done` pulse marks the return to idle.

All downstream levels, bias and conversion are handled elsewhere. Line length, line count, phase durations, sample delay and reset width are parameters.

Top module: `ccd_clock_seq`

## Requirements
- R1: After reset and while idle: vert_a=0, vert_b=0, horz_a=1, horz_b=0, node_rst=0, smp_stb=0, done=0.
- R2: A `start` pulse sampled while idle makes vert_a high in the next cycle for V_CYC cycles. vert_b is then high for V_CYC cycles. The two vertical phases are never high together.
- R3: Every falling edge of vert_b occurs with horz_a high and horz_b low, which transfers one line per edge. There are LINES such edges per readout.
- R4: horz_a and horz_b are complementary in every cycle.
- R5: After each line transfer, PIX pixel periods follow. Each period is horz_b high for H_CYC cycles, then horz_b low for H_CYC cycles.
- R6: In each pixel period, smp_stb is high for exactly one cycle: the cycle at index SAMP_DLY of the horz_b-low half, where index 0 is the first cycle after the horz_b falling edge (SAMP_DLY ≥ 1).
- R7: node_rst is high for RST_W cycles, starting in the cycle after the strobe. It never coincides with the strobe, with horz_b high, or with a horz_b falling edge (SAMP_DLY+RST_W ≤ H_CYC-1).
- R8: vert_a and vert_b stay low throughout horizontal shifting.
- R9: In the cycle after the last pixel period of line LINES, done is high for one cycle and the outputs return to the idle levels of R1.
- R10: A `start` pulse while a readout is in progress has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin readout (one-cycle pulse) |
| vert_a | output | 1 | Vertical phase A |
| vert_b | output | 1 | Vertical phase B |
| horz_a | output | 1 | Horizontal phase A |
| horz_b | output | 1 | Horizontal phase B |
| node_rst | output | 1 | Output node reset gate |
| smp_stb | output | 1 | Sample strobe to external converter |
| done | output | 1 | Readout finished (one cycle) |

## Verification
The assertions assume parameters that satisfy SAMP_DLY ≥ 1 and SAMP_DLY+RST_W < H_CYC, so the strobe and the reset pulse both fit inside the low half of horz_b. They also assume that `start` is a free input with no timing relation to the sequence, so a stray pulse at any point is legal. The stimulus keeps to the default parameters, which satisfy these constraints. It issues `start` from idle and also in the middle of a readout. It compares every output in every cycle of two complete readouts against a waveform computed arithmetically from the requirements. It also applies a reset in the middle of a line.

// File: rtl/ccd_clock_seq.sv
module ccd_clock_seq #(
  parameter int PIX      = 8,
  parameter int LINES    = 4,
  parameter int V_CYC    = 2,
  parameter int H_CYC    = 4,
  parameter int SAMP_DLY = 1,
  parameter int RST_W    = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic vert_a,
  output logic vert_b,
  output logic horz_a,
  output logic horz_b,
  output logic node_rst,
  output logic smp_stb,
  output logic done
);
  localparam int CMAX = (V_CYC > H_CYC) ? V_CYC : H_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int PW   = $clog2(PIX + 1);
  localparam int LW   = $clog2(LINES + 1);
  localparam logic [CW-1:0] V_LAST = CW'(V_CYC - 1);
  localparam logic [CW-1:0] H_LAST = CW'(H_CYC - 1);
  localparam logic [CW-1:0] S_IDX  = CW'(SAMP_DLY);
  localparam logic [CW-1:0] R_END  = CW'(SAMP_DLY + RST_W);
  localparam logic [PW-1:0] P_LAST = PW'(PIX - 1);
  localparam logic [LW-1:0] L_LAST = LW'(LINES - 1);

  typedef enum logic [2:0] {S_IDLE, S_VA, S_VB, S_HHI, S_HLO} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [PW-1:0] pix;
  logic [LW-1:0] line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      pix  <= '0;
      line <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st   <= S_VA;
          cnt  <= '0;
          line <= '0;
        end
        S_VA: if (cnt == V_LAST) begin
          st  <= S_VB;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_VB: if (cnt == V_LAST) begin
          st  <= S_HHI;
          cnt <= '0;
          pix <= '0;
        end else cnt <= cnt + 1'b1;
        S_HHI: if (cnt == H_LAST) begin
          st  <= S_HLO;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_HLO: if (cnt == H_LAST) begin
          cnt <= '0;
          if (pix != P_LAST) begin
            pix <= pix + 1'b1;
            st  <= S_HHI;
          end else if (line != L_LAST) begin
            line <= line + 1'b1;
            st   <= S_VA;
          end else begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign vert_a   = (st == S_VA);
  assign vert_b   = (st == S_VB);
  assign horz_b   = (st == S_HHI);
  assign horz_a   = ~horz_b;
  assign smp_stb  = (st == S_HLO) && (cnt == S_IDX);
  assign node_rst = (st == S_HLO) && (cnt > S_IDX) && (cnt <= R_END);
endmodule

// File: rtl/ccd_clock_seq_chk.sv
module ccd_clock_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic vert_a,
  input logic vert_b,
  input logic horz_a,
  input logic horz_b,
  input logic node_rst,
  input logic smp_stb,
  input logic done
);
  assert_vert_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(vert_a && vert_b));
  assert_xfer_h1_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vert_b) |-> $past(horz_a) && !$past(horz_b));
  assert_horz_compl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    horz_a != horz_b);
  assert_stb_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> !smp_stb);
  assert_rst_after_stb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(node_rst) |-> $past(smp_stb));
  assert_rst_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    node_rst |-> !smp_stb && !horz_b && !$fell(horz_b));
  assert_vert_low_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (horz_b || smp_stb || node_rst) |-> !vert_a && !vert_b);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !vert_a && !vert_b && horz_a && !node_rst && !smp_stb);
endmodule

bind ccd_clock_seq ccd_clock_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vert_a(vert_a), .vert_b(vert_b),
  .horz_a(horz_a), .horz_b(horz_b), .node_rst(node_rst),
  .smp_stb(smp_stb), .done(done)
);

// File: tb/ccd_clock_seq_tb.sv
module ccd_clock_seq_tb;
  localparam int PIX = 8, LINES = 4, V_CYC = 2, H_CYC = 4, SAMP_DLY = 1, RST_W = 1;
  localparam int LLEN  = 2 * V_CYC + 2 * H_CYC * PIX;
  localparam int TOTAL = LINES * LLEN;

  logic clk = 0, rst_n = 0, start = 0;
  logic vert_a, vert_b, horz_a, horz_b, node_rst, smp_stb, done;
  int checks = 0, fails = 0;
  int n_stb, n_rst, n_xfer, n_compl_bad, n_vshift;
  logic pv_b, ph_a;

  always #2 clk = ~clk;

  ccd_clock_seq #(.PIX(PIX), .LINES(LINES), .V_CYC(V_CYC), .H_CYC(H_CYC),
                  .SAMP_DLY(SAMP_DLY), .RST_W(RST_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vert_a(vert_a), .vert_b(vert_b),
    .horz_a(horz_a), .horz_b(horz_b), .node_rst(node_rst), .smp_stb(smp_stb),
    .done(done));

  // {vert_a, vert_b, horz_a, horz_b, node_rst, smp_stb, done}
  function automatic logic [6:0] expv(int c);
    int o, q;
    if (c >= TOTAL) return {4'b0010, 2'b00, c == TOTAL};
    o = c % LLEN;
    if (o < V_CYC) return 7'b1010000;
    if (o < 2 * V_CYC) return 7'b0110000;
    q = (o - 2 * V_CYC) % (2 * H_CYC);
    if (q < H_CYC) return 7'b0001000;
    q = q - H_CYC;
    return {4'b0010, (q > SAMP_DLY && q <= SAMP_DLY + RST_W), q == SAMP_DLY, 1'b0};
  endfunction

  function automatic string tagof(int c);
    int o, q;
    if (c >= TOTAL) return "R9";
    o = c % LLEN;
    if (o < 2 * V_CYC) return "R2";
    q = (o - 2 * V_CYC) % (2 * H_CYC);
    if (q < H_CYC) return "R5";
    q = q - H_CYC;
    if (q == SAMP_DLY) return "R6";
    if (q > SAMP_DLY) return "R7";
    return "R5";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(bit poke);
    n_stb = 0; n_rst = 0; n_xfer = 0; n_compl_bad = 0; n_vshift = 0;
    pv_b = 0; ph_a = 1;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int c = 0; c <= TOTAL + 1; c++) begin
      chk(poke ? {tagof(c), " R10"} : tagof(c),
          {vert_a, vert_b, horz_a, horz_b, node_rst, smp_stb, done}, expv(c));
      n_stb += smp_stb;
      n_rst += node_rst;
      if (pv_b && !vert_b && ph_a) n_xfer++;
      if (horz_a == horz_b) n_compl_bad++;
      if ((horz_b || node_rst || smp_stb) && (vert_a || vert_b)) n_vshift++;
      pv_b = vert_b; ph_a = horz_a;
      start = (poke && (c == 10 || c == TOTAL / 2 || c == TOTAL - 1));
      @(negedge clk);
    end
    start = 0;
    chk("R6 strobe count", n_stb, PIX * LINES);
    chk("R7 reset cycles", n_rst, PIX * LINES * RST_W);
    chk("R3 line transfers", n_xfer, LINES);
    chk("R4 complement", n_compl_bad, 0);
    chk("R8 vert during shift", n_vshift, 0);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        chk("R1 reset state", {vert_a, vert_b, horz_a, horz_b, node_rst, smp_stb, done}, 7'b0010000);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk("R1 idle state", {vert_a, vert_b, horz_a, horz_b, node_rst, smp_stb, done}, 7'b0010000);
        run(0);
        run(1);
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        repeat (9) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        chk("R1 reset mid-run", {vert_a, vert_b, horz_a, horz_b, node_rst, smp_stb, done}, 7'b0010000);
        rst_n = 1;
        run(0);
      end
      begin
        repeat (20000) @(posedge clk);
        chk("watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule